// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller with Write Buffer

This block is a small direct-mapped data cache between a processor word port and a slower main-memory port that moves whole blocks. Each line holds a tag, a valid flag, a dirty flag and a block of 2^OFF_W words. The processor presents a word address and holds its request until `cpu_done` pulses. A read that hits answers in the next cycle. A miss stalls the processor while the line is refilled, and a dirty victim is written out first when the cache runs in write-back mode.

Two parameters select the policy. `WRITE_BACK` chooses between write-back, where a write hit only marks the line dirty, and write-through, where every write is also queued for memory. `WRITE_ALLOC` chooses whether a write miss fills the line or only sends the word to memory. Single words bound for memory wait in a four-entry FIFO, which drains on its own whenever the memory port is free. A block fetch waits until no queued word targets that block.

Top module: `cdm_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_done` and `mem_req` are low, and the first access to any address is a miss.
- R2: A read hit raises `cpu_done` one cycle after the request is accepted, with the stored word on `cpu_rdata`, and starts no memory transaction.
- R3: A read miss issues one block read (`mem_we`=0) at block address `cpu_addr >> OFF_W`, installs the block and then answers; the other words of that block then hit.
- R4: In write-back mode a write hit updates only the cache line and marks it dirty; memory is not written.
- R5: In write-back mode a dirty victim is written out as one block write with every `mem_wmask` bit set, before the fill. A clean victim is dropped without a memory write.
- R6: In write-through mode every write queues its word for memory. The drain writes it with only the `mem_wmask` bit of its word offset set (bit i enables word i, carried in `mem_wdata[i*DW +: DW]`), and no victim is ever written back.
- R7: With write-allocate a write miss fills the line, so a later read of that address hits. Without it a write miss leaves the cache untouched and a later read of that address misses.
- R8: The write FIFO holds 4 words; a write that needs the FIFO stalls only while it is full, and every queued word reaches memory in order.
- R9: A block fetch starts only when no queued word targets that block, so a read after a non-allocated write returns the written value.
- R10: `mem_req` stays high with a stable `mem_addr` and `mem_we` until `mem_ack`; the FIFO drain and the line transfers never own the port together.
- R11: The word offset sits in `cpu_addr[OFF_W-1:0]`, the line index in the next IDX_W bits and the tag in the upper bits, so addresses that differ only in the index are resident together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read word, valid with `cpu_done` |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | AW-OFF_W | Block address |
| mem_wmask | output | 2^OFF_W | Per-word write enable |
| mem_wdata | output | DW*2^OFF_W | Block write data |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rdata | input | DW*2^OFF_W | Block read data, valid with `mem_ack` |

## Verification
A vector table runs mixed reads and writes through a write-back, write-allocate instance. It hits, misses, evicts dirty lines and allocates on write misses to addresses that share an index, and compares every read with a reference image. Directed sequences then look at memory itself. Unchanged memory after a write hit separates write-back from write-through. The memory write count separates a clean victim from a dirty one. A single-word mask shows a drained word apart from a full block write. A second instance, write-through without allocation, runs behind a slow memory. There a read right after a write miss shows whether the fetch waited for the drain, and a run of five write misses shows the stall on a full FIFO.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MISS  = 2'd1,
    ST_EVICT = 2'd2,
    ST_FILL  = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/cdm_wbuf.sv
module cdm_wbuf #(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int OFF_W = 2,
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [AW-1:0]       push_addr,
  input  logic [DW-1:0]       push_data,
  input  logic                pop,
  output logic                full,
  output logic                empty,
  output logic [AW-1:0]       head_addr,
  output logic [DW-1:0]       head_data,
  input  logic [AW-OFF_W-1:0] probe_blk,
  output logic                match_any
);
  localparam int PW = $clog2(DEPTH);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [PW-1:0]    rd_q, wr_q;
  logic [PW:0]      cnt_q;
  logic [DEPTH-1:0] hit_v;

  assign full      = (cnt_q == (PW+1)'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_addr = addr_q[rd_q];
  assign head_data = data_q[rd_q];

  // an entry is live when its distance from the read pointer is below the count
  for (genvar i = 0; i < DEPTH; i++) begin : g_probe
    logic [PW-1:0] rel;
    assign rel      = PW'(i) - rd_q;
    assign hit_v[i] = ({1'b0, rel} < cnt_q) && (addr_q[i][AW-1:OFF_W] == probe_blk);
  end
  assign match_any = |hit_v;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_q] <= push_addr;
      data_q[wr_q] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);  // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R8
endmodule

// File: rtl/cdm_store.sv
module cdm_store #(
  parameter int DW    = 32,
  parameter int OFF_W = 2,
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              idx,
  output logic                          line_valid,
  output logic                          line_dirty,
  output logic [TAG_W-1:0]              line_tag,
  output logic [DW*(1<<OFF_W)-1:0]      line_data,
  input  logic                          fill_en,
  input  logic [TAG_W-1:0]              fill_tag,
  input  logic [DW*(1<<OFF_W)-1:0]      fill_data,
  input  logic                          wr_en,
  input  logic [OFF_W-1:0]              wr_off,
  input  logic [DW-1:0]                 wr_data,
  input  logic                          wr_dirty
);
  localparam int LINES = 1 << IDX_W;
  localparam int BLK_W = DW * (1 << OFF_W);

  logic [BLK_W-1:0] data_q [LINES];
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [LINES-1:0] valid_q, dirty_q;

  assign line_valid = valid_q[idx];
  assign line_dirty = dirty_q[idx];
  assign line_tag   = tag_q[idx];
  assign line_data  = data_q[idx];

  always_ff @(posedge clk) begin
    if (fill_en) begin
      data_q[idx] <= fill_data;
      tag_q[idx]  <= fill_tag;
    end else if (wr_en) begin
      data_q[idx][wr_off*DW +: DW] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (wr_en && wr_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/cdm_cache_ctrl.sv
module cdm_cache_ctrl
  import cdm_pkg::*;
#(
  parameter int AW          = 10,
  parameter int DW          = 32,
  parameter int OFF_W       = 2,
  parameter int IDX_W       = 3,
  parameter int WB_DEPTH    = 4,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [AW-1:0]             cpu_addr,
  input  logic [DW-1:0]             cpu_wdata,
  output logic                      cpu_done,
  output logic [DW-1:0]             cpu_rdata,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [AW-OFF_W-1:0]       mem_addr,
  output logic [(1<<OFF_W)-1:0]     mem_wmask,
  output logic [DW*(1<<OFF_W)-1:0]  mem_wdata,
  input  logic                      mem_ack,
  input  logic [DW*(1<<OFF_W)-1:0]  mem_rdata
);
  localparam int TAG_W = AW - IDX_W - OFF_W;
  localparam int WORDS = 1 << OFF_W;
  localparam int BLK_W = DW * WORDS;
  localparam int BA_W  = AW - OFF_W;

  function automatic logic [OFF_W-1:0] f_off(input logic [AW-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [IDX_W-1:0] f_idx(input logic [AW-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [AW-1:0] a);
    return a[AW-1 -: TAG_W];
  endfunction
  function automatic logic [BA_W-1:0] f_blk(input logic [AW-1:0] a);
    return a[AW-1:OFF_W];
  endfunction

  ctl_state_e state_q;
  logic       done_q, evicted_q, drain_busy;
  logic [DW-1:0] rdata_q;

  logic             line_valid, line_dirty;
  logic [TAG_W-1:0] line_tag;
  logic [BLK_W-1:0] line_data;
  logic             buf_full, buf_empty, match_any;
  logic [AW-1:0]    head_addr;
  logic [DW-1:0]    head_data;

  // named internal events
  logic hit, accept_ok, rd_hit_go, wr_hit_go, wr_nwa_go, miss_go, buf_push;
  logic need_evict, evict_go, fill_go, drain_go, evict_done, fill_done, drain_done;

  assign hit        = line_valid && (line_tag == f_tag(cpu_addr));
  assign accept_ok  = (state_q == ST_IDLE) && cpu_req && !done_q;
  assign rd_hit_go  = accept_ok && !cpu_we && hit;
  assign wr_hit_go  = accept_ok && cpu_we && hit && (WRITE_BACK || !buf_full);
  assign wr_nwa_go  = accept_ok && cpu_we && !hit && !WRITE_ALLOC && !buf_full;
  assign miss_go    = accept_ok && !hit && (!cpu_we || WRITE_ALLOC);
  assign buf_push   = (wr_hit_go && !WRITE_BACK) || wr_nwa_go;

  assign need_evict = WRITE_BACK && line_valid && line_dirty && !evicted_q;
  assign evict_go   = (state_q == ST_MISS) && !drain_busy && need_evict;
  assign fill_go    = (state_q == ST_MISS) && !drain_busy && !need_evict && !match_any;
  assign drain_go   = !drain_busy && !buf_empty &&
                      ((state_q == ST_IDLE) || ((state_q == ST_MISS) && !evict_go && !fill_go));
  assign evict_done = (state_q == ST_EVICT) && mem_ack;
  assign fill_done  = (state_q == ST_FILL) && mem_ack;
  assign drain_done = drain_busy && mem_ack;

  cdm_store #(.DW(DW), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(f_idx(cpu_addr)),
    .line_valid(line_valid), .line_dirty(line_dirty), .line_tag(line_tag), .line_data(line_data),
    .fill_en(fill_done), .fill_tag(f_tag(cpu_addr)), .fill_data(mem_rdata),
    .wr_en(wr_hit_go), .wr_off(f_off(cpu_addr)), .wr_data(cpu_wdata), .wr_dirty(WRITE_BACK)
  );

  cdm_wbuf #(.AW(AW), .DW(DW), .OFF_W(OFF_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .push(buf_push), .push_addr(cpu_addr), .push_data(cpu_wdata),
    .pop(drain_done), .full(buf_full), .empty(buf_empty), .head_addr(head_addr),
    .head_data(head_data), .probe_blk(f_blk(cpu_addr)), .match_any(match_any)
  );

  // memory port: line transfers own it in EVICT/FILL, otherwise the drain
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wmask = '0;
    mem_wdata = '0;
    if (state_q == ST_EVICT) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = {line_tag, f_idx(cpu_addr)};
      mem_wmask = '1;
      mem_wdata = line_data;
    end else if (state_q == ST_FILL) begin
      mem_req   = 1'b1;
      mem_addr  = f_blk(cpu_addr);
    end else if (drain_busy) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = f_blk(head_addr);
      mem_wmask = WORDS'(1) << f_off(head_addr);
      mem_wdata = {WORDS{head_data}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      done_q     <= 1'b0;
      evicted_q  <= 1'b0;
      drain_busy <= 1'b0;
      rdata_q    <= '0;
    end else begin
      done_q <= rd_hit_go || wr_hit_go || wr_nwa_go;
      if (rd_hit_go) rdata_q <= line_data[f_off(cpu_addr)*DW +: DW];
      if (drain_go) drain_busy <= 1'b1;
      else if (drain_done) drain_busy <= 1'b0;
      case (state_q)
        ST_IDLE:  if (miss_go) state_q <= ST_MISS;
        ST_MISS:  if (evict_go) state_q <= ST_EVICT;
                  else if (fill_go) state_q <= ST_FILL;
        ST_EVICT: if (evict_done) begin
                    state_q   <= ST_MISS;
                    evicted_q <= 1'b1;
                  end
        ST_FILL:  if (fill_done) begin
                    state_q   <= ST_IDLE;
                    evicted_q <= 1'b0;
                  end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R10
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    drain_busy |-> !((state_q == ST_EVICT) || (state_q == ST_FILL)));  // R10
  AST_FILL_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL) |-> !match_any);  // R9
  AST_WT_NO_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVICT) |-> WRITE_BACK);  // R6
  AST_NWA_NO_WRITE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_FILL) && cpu_we) |-> WRITE_ALLOC);  // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);  // R2
endmodule

// File: tb/tb_cdm_cache_ctrl.sv
module tb_mem #(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int OFF_W = 2,
  parameter int LAT   = 3
) (
  input  logic                      clk,
  input  logic                      req,
  input  logic                      we,
  input  logic [AW-OFF_W-1:0]       addr,
  input  logic [(1<<OFF_W)-1:0]     wmask,
  input  logic [DW*(1<<OFF_W)-1:0]  wdata,
  output logic                      ack,
  output logic [DW*(1<<OFF_W)-1:0]  rdata
);
  logic [DW-1:0] m [1<<AW];
  int rd_cnt = 0, wr_cnt = 0, hold_err = 0, cnt = 0;
  logic pend = 1'b0, p_we = 1'b0;
  logic [AW-OFF_W-1:0] p_addr = '0;
  logic [AW-OFF_W-1:0] last_raddr = '0;

  initial begin
    ack = 1'b0;
    rdata = '0;
    for (int a = 0; a < (1<<AW); a++) m[a] = DW'(32'hA500_0000 | a);
  end

  always @(negedge clk) begin
    if (pend && (!req || addr != p_addr || we != p_we)) hold_err++;
    if (ack) begin
      ack = 1'b0; cnt = 0; pend = 1'b0;
    end else if (req) begin
      cnt++;
      pend = 1'b1; p_addr = addr; p_we = we;
      if (cnt >= LAT) begin
        ack = 1'b1; pend = 1'b0;
        if (we) begin
          wr_cnt++;
          for (int i = 0; i < (1<<OFF_W); i++)
            if (wmask[i]) m[{addr, OFF_W'(i)}] = wdata[i*DW +: DW];
        end else begin
          rd_cnt++;
          last_raddr = addr;
          for (int i = 0; i < (1<<OFF_W); i++) rdata[i*DW +: DW] = m[{addr, OFF_W'(i)}];
        end
      end
    end
  end
endmodule

module tb_cdm_cache_ctrl;
  localparam int AW = 10, DW = 32, OFF_W = 2, IDX_W = 3;
  localparam int BLK_W = DW << OFF_W, NW = 1 << OFF_W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // instance A: write-back, write-allocate; instance B: write-through, no allocate
  logic a_req = 0, a_we = 0, a_done, a_mreq, a_mwe, a_mack;
  logic [AW-1:0] a_addr = '0; logic [DW-1:0] a_wd = '0, a_rd;
  logic [AW-OFF_W-1:0] a_maddr; logic [NW-1:0] a_mmask; logic [BLK_W-1:0] a_mwd, a_mrd;
  logic b_req = 0, b_we = 0, b_done, b_mreq, b_mwe, b_mack;
  logic [AW-1:0] b_addr = '0; logic [DW-1:0] b_wd = '0, b_rd;
  logic [AW-OFF_W-1:0] b_maddr; logic [NW-1:0] b_mmask; logic [BLK_W-1:0] b_mwd, b_mrd;

  cdm_cache_ctrl #(.AW(AW), .DW(DW), .OFF_W(OFF_W), .IDX_W(IDX_W), .WB_DEPTH(4),
                   .WRITE_BACK(1'b1), .WRITE_ALLOC(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(a_req), .cpu_we(a_we), .cpu_addr(a_addr),
    .cpu_wdata(a_wd), .cpu_done(a_done), .cpu_rdata(a_rd), .mem_req(a_mreq), .mem_we(a_mwe),
    .mem_addr(a_maddr), .mem_wmask(a_mmask), .mem_wdata(a_mwd), .mem_ack(a_mack), .mem_rdata(a_mrd));
  tb_mem #(.AW(AW), .DW(DW), .OFF_W(OFF_W), .LAT(3)) mem_a (
    .clk(clk), .req(a_mreq), .we(a_mwe), .addr(a_maddr), .wmask(a_mmask), .wdata(a_mwd),
    .ack(a_mack), .rdata(a_mrd));

  cdm_cache_ctrl #(.AW(AW), .DW(DW), .OFF_W(OFF_W), .IDX_W(IDX_W), .WB_DEPTH(4),
                   .WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) dut_wt (
    .clk(clk), .rst_n(rst_n), .cpu_req(b_req), .cpu_we(b_we), .cpu_addr(b_addr),
    .cpu_wdata(b_wd), .cpu_done(b_done), .cpu_rdata(b_rd), .mem_req(b_mreq), .mem_we(b_mwe),
    .mem_addr(b_maddr), .mem_wmask(b_mmask), .mem_wdata(b_mwd), .mem_ack(b_mack), .mem_rdata(b_mrd));
  tb_mem #(.AW(AW), .DW(DW), .OFF_W(OFF_W), .LAT(30)) mem_b (
    .clk(clk), .req(b_mreq), .we(b_mwe), .addr(b_maddr), .wmask(b_mmask), .wdata(b_mwd),
    .ack(b_mack), .rdata(b_mrd));

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [DW-1:0] shadow [1<<AW];

  function automatic logic [DW-1:0] orig(input int a);
    return DW'(32'hA500_0000 | a);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one processor access; lat = cycles from the accepting edge to seeing done
  task automatic op(input int u, input bit we, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                    output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    if (u == 0) begin a_req = 1; a_we = we; a_addr = addr; a_wd = wd; end
    else        begin b_req = 1; b_we = we; b_addr = addr; b_wd = wd; end
    lat = 0;
    forever begin
      @(posedge clk); @(negedge clk); lat++;
      if ((u == 0 && a_done) || (u == 1 && b_done) || lat > 2000) break;
    end
    rd = (u == 0) ? a_rd : b_rd;
    if (u == 0) a_req = 0; else b_req = 0;
    if (we && u == 0) shadow[addr] = wd;
    @(posedge clk);
  endtask

  typedef struct packed { logic we; logic [9:0] addr; logic [31:0] data; } vec_t;
  localparam vec_t VECS [12] = '{
    '{1'b0, 10'h004, 32'h0},          '{1'b0, 10'h005, 32'h0},
    '{1'b1, 10'h006, 32'h1111_1111}, '{1'b0, 10'h006, 32'h0},
    '{1'b0, 10'h024, 32'h0},          '{1'b0, 10'h006, 32'h0},
    '{1'b1, 10'h0F3, 32'h2222_2222}, '{1'b0, 10'h0F3, 32'h0},
    '{1'b1, 10'h0F0, 32'h3333_3333}, '{1'b0, 10'h013, 32'h0},
    '{1'b0, 10'h0F0, 32'h0},          '{1'b0, 10'h3FF, 32'h0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    int lat, c0, c1;
    for (int a = 0; a < (1<<AW); a++) shadow[a] = orig(a);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!a_done && !a_mreq && !b_done && !b_mreq, "R1 reset outputs", {a_done, a_mreq, b_done, b_mreq}, 0);
    rst_n = 1;

    // table walk on the write-back, write-allocate instance (R3, R5, R7, R11)
    for (int i = 0; i < 12; i++) begin
      op(0, VECS[i].we, VECS[i].addr, VECS[i].data, rd, lat);
      if (!VECS[i].we)
        chk(rd == shadow[VECS[i].addr], $sformatf("R3 table vector %0d", i), rd, shadow[VECS[i].addr]);
    end
    chk(mem_a.m[10'h006] == 32'h1111_1111, "R5 dirty victim in memory", mem_a.m[10'h006], 32'h1111_1111);
    chk(mem_a.m[10'h0F0] == 32'h3333_3333, "R5 allocated write evicted", mem_a.m[10'h0F0], 32'h3333_3333);

    // R1/R3: first access misses and fetches exactly one block
    c0 = mem_a.rd_cnt;
    op(0, 0, 10'h100, 0, rd, lat);
    chk(lat > 1 && mem_a.rd_cnt == c0 + 1, "R1 first access is a miss", mem_a.rd_cnt, c0 + 1);
    chk(mem_a.last_raddr == 8'h40, "R3 fill block address", mem_a.last_raddr, 8'h40);
    chk(rd == orig(10'h100), "R3 miss data", rd, orig(10'h100));
    // R2: hit in the next cycle without memory traffic
    op(0, 0, 10'h101, 0, rd, lat);
    chk(lat == 1, "R2 hit latency", lat, 1);
    chk(rd == orig(10'h101) && mem_a.rd_cnt == c0 + 1, "R2 hit data no fetch", rd, orig(10'h101));
    // R4: write hit stays in cache
    c1 = mem_a.wr_cnt;
    op(0, 1, 10'h102, 32'hDEAD_0102, rd, lat);
    repeat (20) @(posedge clk);
    chk(mem_a.m[10'h102] == orig(10'h102) && mem_a.wr_cnt == c1, "R4 memory untouched", mem_a.m[10'h102], orig(10'h102));
    op(0, 0, 10'h102, 0, rd, lat);
    chk(rd == 32'hDEAD_0102 && lat == 1, "R4 cached value", rd, 32'hDEAD_0102);
    // R5: dirty victim as one full-mask block write, clean victim dropped
    op(0, 0, 10'h122, 0, rd, lat);
    chk(mem_a.wr_cnt == c1 + 1 && mem_a.m[10'h102] == 32'hDEAD_0102, "R5 dirty writeback", mem_a.m[10'h102], 32'hDEAD_0102);
    chk(mem_a.m[10'h100] == orig(10'h100), "R5 block neighbour intact", mem_a.m[10'h100], orig(10'h100));
    op(0, 0, 10'h142, 0, rd, lat);
    chk(mem_a.wr_cnt == c1 + 1, "R5 clean victim no write", mem_a.wr_cnt, c1 + 1);
    // R7: write-allocate -> later read hits
    op(0, 1, 10'h1A1, 32'h0A11_0C00, rd, lat);
    c0 = mem_a.rd_cnt;
    op(0, 0, 10'h1A1, 0, rd, lat);
    chk(lat == 1 && rd == 32'h0A11_0C00 && mem_a.rd_cnt == c0, "R7 write allocate hit", rd, 32'h0A11_0C00);
    // R11: lines differing only in index coexist
    op(0, 0, 10'h3E0, 0, rd, lat);
    op(0, 0, 10'h3E4, 0, rd, lat);
    op(0, 0, 10'h3E0, 0, rd, lat);
    chk(lat == 1 && rd == orig(10'h3E0), "R11 index separation", lat, 1);

    // write-through, no-allocate instance
    op(1, 0, 10'h200, 0, rd, lat);
    c1 = mem_b.wr_cnt;
    op(1, 1, 10'h201, 32'hB0B0_0201, rd, lat);
    chk(lat == 1, "R6 write hit latency", lat, 1);
    repeat (60) @(posedge clk);
    chk(mem_b.m[10'h201] == 32'hB0B0_0201 && mem_b.wr_cnt == c1 + 1, "R6 word written through", mem_b.m[10'h201], 32'hB0B0_0201);
    chk(mem_b.m[10'h200] == orig(10'h200), "R6 single word mask", mem_b.m[10'h200], orig(10'h200));
    op(1, 0, 10'h201, 0, rd, lat);
    chk(rd == 32'hB0B0_0201 && lat == 1, "R6 cache updated", rd, 32'hB0B0_0201);
    op(1, 0, 10'h221, 0, rd, lat);
    chk(mem_b.wr_cnt == c1 + 1, "R6 no victim writeback", mem_b.wr_cnt, c1 + 1);
    // R7/R9: write miss not allocated; read waits for drain
    c0 = mem_b.rd_cnt;
    op(1, 1, 10'h305, 32'h5EED_0305, rd, lat);
    chk(lat == 1, "R8 write miss not stalled", lat, 1);
    op(1, 0, 10'h305, 0, rd, lat);
    chk(mem_b.rd_cnt == c0 + 1, "R7 no-allocate read misses", mem_b.rd_cnt, c0 + 1);
    chk(rd == 32'h5EED_0305, "R9 drain before fetch", rd, 32'h5EED_0305);
    // R8: four writes fit, the fifth stalls
    for (int i = 0; i < 5; i++) begin
      op(1, 1, AW'(10'h340 + i), 32'hF1F0_0000 + i, rd, lat);
      if (i < 4) chk(lat == 1, $sformatf("R8 write %0d no stall", i), lat, 1);
      else       chk(lat > 1, "R8 fifth write stalls", lat, 2);
    end
    repeat (300) @(posedge clk);
    for (int i = 0; i < 5; i++)
      chk(mem_b.m[10'h340 + i] == 32'hF1F0_0000 + i, "R8 queued word reached memory", mem_b.m[10'h340 + i], 32'hF1F0_0000 + i);

    // R10: handshake held stable on both ports
    chk(mem_a.hold_err == 0 && mem_b.hold_err == 0, "R10 request held until ack", mem_a.hold_err + mem_b.hold_err, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule